// File: doc/BRIEF.md
# Short Backward Branch Loop Cache

This block sits next to a level-1 instruction cache in front of a single-issue fetch stage. It watches the fetch address stream and the taken-branch reports. When a short backward branch is taken, it records that branch and captures the next pass through the loop body into a small tagless buffer. If the same branch is then taken again, later passes are served from the buffer and the level-1 cache is switched off for those fetches.

The buffer needs no tags because its index is the word offset of the fetch address from the recorded loop target. Any other taken transfer of control, or the loop branch falling through, ends loop mode, and fetch goes back to level 1 on the next cycle. The fetch stage takes the buffer word when `lc_sel` is high and the level-1 word when it is low. Buffer reads are combinational, so a hit costs no extra cycle.

Top module: `lc_loop_cache`

## Requirements
- R1: After reset the controller is idle. In idle and fill states every valid fetch is served by level 1 (`l1_en`=1, `lc_sel`=0), and the returned word equals the memory word at `fetch_pc`.
- R2: A taken branch counts as short backward only when its target is strictly below its source, the difference is a multiple of 4, and the difference divided by 4 is less than DEPTH. A self-loop or a span of DEPTH or more words never starts capture, and every pass of such a loop is served by level 1.
- R3: A short backward branch taken in idle moves the controller to fill. Each valid fetch during fill whose address lies in [target, source] stores the level-1 word at buffer index (pc - target)/4.
- R4: In fill, a taken report whose source equals the recorded branch address moves the controller to active. While active, every valid fetch in [target, source] is served from the buffer (`lc_sel`=1, `l1_en`=0) with the word captured during fill. Repeated taken reports of that branch keep it active.
- R5: A valid fetch of the recorded branch address with no taken report (fall-through) returns the controller to idle. When active, that fetch is still served from the buffer, and the next fetch comes from level 1.
- R6: In active state, a taken report from any other source that is not short backward returns the controller to idle. The branching fetch itself is still served from the buffer, and the fetch at the branch target comes from level 1.
- R7: In fill, a taken report from any source other than the recorded branch abandons the fill and returns the controller to idle. The loop then needs another taken pass to fill again and one more to become active.
- R8: In active state, a taken short backward branch with a different source restarts fill with that branch as the recorded loop. Its next pass is captured from level 1 at indices relative to its own target, and later passes are served from the buffer.
- R9: `l1_en` equals `fetch_valid` and not `lc_sel`. `lc_sel` is never high without `fetch_valid`.
- R10: Cycles with `fetch_valid` low change neither the state nor the buffer. Branch reports in such cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid | input | 1 | A fetch happens this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| l1_instr | input | INSTR_W | Word returned by level 1 in the same cycle |
| br_taken | input | 1 | The fetched instruction is a taken transfer of control |
| br_src_pc | input | PC_W | Source address of the taken transfer |
| br_tgt_pc | input | PC_W | Target address of the taken transfer |
| lc_instr | output | INSTR_W | Word read from the loop buffer |
| lc_sel | output | 1 | 1: use `lc_instr`; 0: use `l1_instr` |
| l1_en | output | 1 | Level-1 access enable for this fetch |

## Verification
The hardest situations to reach from the ports are leaving a loop in the middle of an active pass and switching from one active loop to a different short loop. In both, the exit cycle is served from the buffer and the cycle after it is not, so a one-cycle slip would show. The bench has a PC sequencer that walks loop bodies with scripted branch reports. It places a forward branch at each body position of an active pass, an in-body skip at several positions of the fill pass, and an inner backward branch from the middle of an active pass whose target is offset from the old one. The level-1 word is replaced by a poison value whenever `l1_en` is low, so a wrong select or a stale buffer index shows up as a data mismatch.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_IDLE   = 2'd0,
    LC_FILL   = 2'd1,
    LC_ACTIVE = 2'd2
  } lc_state_e;
endpackage

// File: rtl/lc_window.sv
// Address arithmetic: buffer index, loop-window membership, branch classification.
module lc_window #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [PC_W-1:0]  loop_tgt,
  input  logic [PC_W-1:0]  loop_src,
  input  logic [PC_W-1:0]  br_src_pc,
  input  logic [PC_W-1:0]  br_tgt_pc,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             fetch_in_loop,
  output logic             fetch_is_src,
  output logic             br_short_bwd,
  output logic             br_is_loop
);
  logic [PC_W-1:0] fetch_off;
  logic [PC_W-1:0] loop_span;
  logic [PC_W-1:0] br_dist;

  always_comb begin
    fetch_off     = fetch_pc - loop_tgt;
    loop_span     = loop_src - loop_tgt;
    // unsigned compare: an address below the target wraps to a large offset
    fetch_in_loop = (fetch_off[1:0] == 2'b00) && (fetch_off <= loop_span);
    fetch_idx     = fetch_off[IDX_W+1:2];
    fetch_is_src  = (fetch_pc == loop_src);
    br_dist       = br_src_pc - br_tgt_pc;
    br_short_bwd  = (br_tgt_pc < br_src_pc) && (br_dist[1:0] == 2'b00) &&
                    ((br_dist >> 2) < PC_W'(DEPTH));
    br_is_loop    = (br_src_pc == loop_src);
  end
endmodule

// File: rtl/lc_ctrl.sv
// Idle / fill / active sequencing and the recorded loop bounds.
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic            br_taken,
  input  logic            br_short_bwd,
  input  logic            br_is_loop,
  input  logic            fetch_is_src,
  input  logic            fetch_in_loop,
  input  logic [PC_W-1:0] br_src_pc,
  input  logic [PC_W-1:0] br_tgt_pc,
  output lc_state_e       state_q,
  output logic [PC_W-1:0] loop_src_q,
  output logic [PC_W-1:0] loop_tgt_q
);
  lc_state_e state_d;
  logic      capture;
  logic      ev_taken;
  logic      ev_fall;
  logic      ev_stray;

  always_comb begin
    ev_taken = fetch_valid && br_taken;
    ev_fall  = fetch_valid && !br_taken && fetch_is_src;
    ev_stray = fetch_valid && !br_taken && !fetch_in_loop;
    state_d  = state_q;
    capture  = 1'b0;
    unique case (state_q)
      LC_IDLE: begin
        if (ev_taken && br_short_bwd) begin
          state_d = LC_FILL;
          capture = 1'b1;
        end
      end
      LC_FILL: begin
        if (ev_taken) begin
          state_d = br_is_loop ? LC_ACTIVE : LC_IDLE;
        end else if (ev_fall || ev_stray) begin
          state_d = LC_IDLE;
        end
      end
      LC_ACTIVE: begin
        if (ev_taken) begin
          if (br_is_loop) begin
            state_d = LC_ACTIVE;
          end else if (br_short_bwd) begin
            state_d = LC_FILL;
            capture = 1'b1;
          end else begin
            state_d = LC_IDLE;
          end
        end else if (ev_fall || ev_stray) begin
          state_d = LC_IDLE;
        end
      end
      default: state_d = LC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LC_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_src_q <= '0;
      loop_tgt_q <= '0;
    end else if (capture) begin
      loop_src_q <= br_src_pc;
      loop_tgt_q <= br_tgt_pc;
    end
  end
endmodule

// File: rtl/lc_store.sv
// Tagless loop buffer: per-entry write enables, combinational read.
module lc_store #(
  parameter int DEPTH   = 16,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [INSTR_W-1:0] rd_data
);
  logic [INSTR_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        ent_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = ent_q[i];
    end
  end
endmodule

// File: rtl/lc_loop_cache.sv
module lc_loop_cache
  import lc_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [PC_W-1:0]    fetch_pc,
  input  logic [INSTR_W-1:0] l1_instr,
  input  logic               br_taken,
  input  logic [PC_W-1:0]    br_src_pc,
  input  logic [PC_W-1:0]    br_tgt_pc,
  output logic [INSTR_W-1:0] lc_instr,
  output logic               lc_sel,
  output logic               l1_en
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lc_state_e        state_q;
  logic [PC_W-1:0]  loop_src_q;
  logic [PC_W-1:0]  loop_tgt_q;
  logic [IDX_W-1:0] fetch_idx;
  logic             fetch_in_loop;
  logic             fetch_is_src;
  logic             br_short_bwd;
  logic             br_is_loop;
  logic             buf_wr;
  logic             buf_hit;

  lc_window #(.PC_W(PC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) win_i (
    .fetch_pc      (fetch_pc),
    .loop_tgt      (loop_tgt_q),
    .loop_src      (loop_src_q),
    .br_src_pc     (br_src_pc),
    .br_tgt_pc     (br_tgt_pc),
    .fetch_idx     (fetch_idx),
    .fetch_in_loop (fetch_in_loop),
    .fetch_is_src  (fetch_is_src),
    .br_short_bwd  (br_short_bwd),
    .br_is_loop    (br_is_loop)
  );

  lc_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .br_taken      (br_taken),
    .br_short_bwd  (br_short_bwd),
    .br_is_loop    (br_is_loop),
    .fetch_is_src  (fetch_is_src),
    .fetch_in_loop (fetch_in_loop),
    .br_src_pc     (br_src_pc),
    .br_tgt_pc     (br_tgt_pc),
    .state_q       (state_q),
    .loop_src_q    (loop_src_q),
    .loop_tgt_q    (loop_tgt_q)
  );

  always_comb begin
    buf_wr  = fetch_valid && (state_q == LC_FILL)   && fetch_in_loop;
    buf_hit = fetch_valid && (state_q == LC_ACTIVE) && fetch_in_loop;
    lc_sel  = buf_hit;
    l1_en   = fetch_valid && !buf_hit;
  end

  lc_store #(.DEPTH(DEPTH), .INSTR_W(INSTR_W), .IDX_W(IDX_W)) store_i (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_idx  (fetch_idx),
    .wr_data (l1_instr),
    .rd_idx  (fetch_idx),
    .rd_data (lc_instr)
  );
endmodule

// File: rtl/lc_loop_cache_chk.sv
module lc_loop_cache_chk
  import lc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            br_taken,
  input logic [PC_W-1:0] br_src_pc,
  input logic            lc_sel,
  input logic            l1_en,
  input lc_state_e       state_q,
  input logic [PC_W-1:0] loop_src_q,
  input logic            br_short_bwd
);
  AST_IDLE_USES_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && state_q != LC_ACTIVE) |-> (l1_en && !lc_sel)); // R1

  AST_FILL_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_FILL && $past(state_q) == LC_IDLE) |->
      $past(fetch_valid && br_taken && br_short_bwd)); // R2

  AST_ACTIVE_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_ACTIVE && $past(state_q) != LC_ACTIVE) |->
      $past(state_q == LC_FILL && fetch_valid && br_taken && br_src_pc == loop_src_q)); // R4

  AST_FALL_THROUGH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != LC_IDLE && fetch_valid && !br_taken && fetch_pc == loop_src_q) |=>
      (state_q == LC_IDLE)); // R5

  AST_FILL_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LC_FILL && fetch_valid && br_taken && br_src_pc != loop_src_q) |=>
      (state_q == LC_IDLE)); // R7

  AST_BUF_GATES_L1: assert property (@(posedge clk) disable iff (!rst_n)
    lc_sel |-> (fetch_valid && !l1_en)); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(state_q)); // R10
endmodule

bind lc_loop_cache lc_loop_cache_chk #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .br_taken     (br_taken),
  .br_src_pc    (br_src_pc),
  .lc_sel       (lc_sel),
  .l1_en        (l1_en),
  .state_q      (state_q),
  .loop_src_q   (loop_src_q),
  .br_short_bwd (br_short_bwd)
);

// File: tb/lc_loop_cache_tb_top.sv
`timescale 1ns/1ps
module lc_loop_cache_tb_top;
  localparam int DEPTH = 16;
  localparam logic [31:0] POISON = 32'hBAD0_BAD0;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic [31:0] l1_instr;
  logic        br_taken;
  logic [31:0] br_src_pc;
  logic [31:0] br_tgt_pc;
  logic [31:0] lc_instr;
  logic        lc_sel;
  logic        l1_en;

  int n_cmp;
  int n_bad;
  bit done;

  lc_loop_cache #(.PC_W(32), .INSTR_W(32), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .l1_instr(l1_instr), .br_taken(br_taken), .br_src_pc(br_src_pc),
    .br_tgt_pc(br_tgt_pc), .lc_instr(lc_instr), .lc_sel(lc_sel), .l1_en(l1_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] pc);
    return {pc[17:2] ^ 16'h5A3C, ~pc[17:2]};
  endfunction

  // level-1 model: answers only when enabled, poison otherwise
  always_comb l1_instr = l1_en ? mem_word(fetch_pc) : POISON;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one fetch cycle; exp_buf says whether the buffer must serve it
  task automatic fetch(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                       input bit exp_buf, input string req);
    logic [31:0] got;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    br_taken    = tk;
    br_src_pc   = pc;
    br_tgt_pc   = tgt;
    #1;
    got = lc_sel ? lc_instr : l1_instr;
    chk(lc_sel == exp_buf, req, {31'd0, lc_sel}, {31'd0, exp_buf});
    chk(l1_en == !exp_buf, "R9", {31'd0, l1_en}, {31'd0, !exp_buf});
    chk(got == mem_word(pc), req, got, mem_word(pc));
  endtask

  // bubble cycle carrying a bogus taken report that must be ignored (R10)
  task automatic bubble();
    @(negedge clk);
    fetch_valid = 1'b0;
    br_taken    = 1'b1;
    br_src_pc   = 32'h0000_F000;
    br_tgt_pc   = 32'h0000_0100;
    #1;
    chk(!lc_sel && !l1_en, "R10", {30'd0, lc_sel, l1_en}, 32'd0);
  endtask

  // Walks a loop at base with span d words, for iters passes.
  // ab_m >= 0: in pass 2 the fetch at body index ab_m skips one word forward (R7).
  // ex_it > 0: in pass ex_it the fetch at index ex_m branches far away (R6).
  task automatic run_loop(input logic [31:0] base, input int d, input int iters,
                          input int ab_m, input int ex_it, input int ex_m,
                          input bit stall);
    bit short_br;
    int act_from;
    logic [31:0] src;
    src      = base + 32'(4 * d);
    short_br = (d >= 1) && (d < DEPTH);
    act_from = (ab_m >= 0) ? 4 : 3;
    for (int it = 1; it <= iters; it++) begin
      bit eb;
      string rq;
      int k;
      eb = short_br && (it >= act_from);
      rq = !short_br ? "R2" : (eb ? "R4" : "R3");
      k  = 0;
      while (k <= d) begin
        logic [31:0] pc;
        pc = base + 32'(4 * k);
        if (stall && (k % 3 == 1)) bubble();
        if (ex_it == it && ex_m == k) begin
          fetch(pc, 1'b1, 32'h0008_0000, eb, "R6");
          fetch(32'h0008_0000, 1'b0, 32'd0, 1'b0, "R6");
          return;
        end
        if (ab_m >= 0 && it == 2 && k == ab_m) begin
          fetch(pc, 1'b1, pc + 32'd8, 1'b0, "R7");
          k = k + 2;
        end else begin
          fetch(pc, (k == d) && (it < iters), base, eb, rq);
          k = k + 1;
        end
      end
    end
    fetch(src + 32'd4, 1'b0, 32'd0, 1'b0, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0;
    br_taken = 1'b0; br_src_pc = '0; br_tgt_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!lc_sel && !l1_en, "R1", {30'd0, lc_sel, l1_en}, 32'd0);
    fetch(32'h0000_0040, 1'b0, 32'd0, 1'b0, "R1");
    fetch(32'h0000_0044, 1'b0, 32'd0, 1'b0, "R1");

    // span sweep: 0 (self loop) .. DEPTH (too long), R2/R3/R4/R5, stalls in some
    for (int d = 0; d <= DEPTH; d++) begin
      run_loop(32'h0001_0000 + 32'(d * 32'h200), d, 5, -1, 0, 0, (d % 3) == 0);
    end

    // fill abandoned at several body positions (R7)
    for (int m = 0; m <= 3; m++) begin
      run_loop(32'h0003_0000 + 32'(m * 32'h100), 6, 6, m, 0, 0, 1'b0);
    end

    // early exit from an active pass at every body index (R6)
    for (int m = 0; m <= 6; m++) begin
      run_loop(32'h0004_0000 + 32'(m * 32'h100), 6, 6, -1, 4, m, 1'b0);
    end

    // R8: switch from active loop A to inner loop B with a different target
    begin
      logic [31:0] ba;
      ba = 32'h0005_0000;
      for (int it = 1; it <= 2; it++) begin
        for (int k = 0; k <= 8; k++) begin
          fetch(ba + 32'(4 * k), k == 8, ba, 1'b0, "R3");
        end
      end
      for (int k = 0; k < 5; k++) fetch(ba + 32'(4 * k), 1'b0, 32'd0, 1'b1, "R4");
      fetch(ba + 32'd20, 1'b1, ba + 32'd4, 1'b1, "R8");
      for (int it = 1; it <= 3; it++) begin
        for (int k = 1; k <= 5; k++) begin
          fetch(ba + 32'(4 * k), (k == 5) && (it < 3), ba + 32'd4, it > 1, "R8");
        end
      end
      fetch(ba + 32'd24, 1'b0, 32'd0, 1'b0, "R8");
    end

    @(negedge clk);
    fetch_valid = 1'b0;
    br_taken    = 1'b0;
    repeat (2) @(posedge clk);
    summary();
  end
endmodule